// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a supervisory timer for a small 8-bit controller. A free-running prescaler divides the system clock. A second counter stage follows it and offers a set of binary taps. A 3-bit select code in the control register picks one tap, and that tap sets the time-out interval. The wall-clock length of every interval therefore scales with the clock frequency. When the chosen interval runs out, the block sends a one-cycle reset request to the reset generator and sets a time-out flag that stays set.

Software reaches the block through one 8-bit control register on a simple special-function-register bus. The bus has an address, a write strobe, write data and combinational read data. The register holds an enable bit, a self-clearing restart bit, a flag that keeps the timer counting while the core is idle, and the tap select. Firmware that runs normally writes the restart bit often enough to stay ahead of the interval. An idle-status input from the power controller pauses counting unless the idle flag allows it.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x00, the reset request is low, the time-out flag is low and the timer is disabled.
- R2: At the register address (default 0x8F), read data returns the enable bit in bit 7, the idle-run flag in bit 5 and the tap select in bits 2..0. Bits 6, 4 and 3 always read 0. Any other address reads 0x00.
- R3: With bit 7 set and select code n, the first reset request comes exactly 2^(BASE_EXP+n) counting cycles after the enabling write. Later requests repeat with the same period.
- R4: The reset request is high for exactly one clock cycle per time-out.
- R5: The time-out flag rises with the first reset request and stays high until the external reset.
- R6: A register write with bit 6 set restarts both the prescaler and the tap counter, so the next request comes a full interval after that write. Bit 6 reads back as 0.
- R7: While the idle input is high and the idle-run flag is 0, counting is suspended. The interval is lengthened by exactly the number of idle cycles.
- R8: While the idle input is high and the idle-run flag is 1, counting continues at the normal rate.
- R9: With bit 7 clear, no reset request is produced and both counters are held at zero. Enabling later gives a full interval.
- R10: Writes to any address other than the register address leave the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | ADDR_W | Register bus address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational) |
| idle_i | input | 1 | Core idle-mode status |
| wdt_rst_req_o | output | 1 | One-cycle system reset request on time-out |
| wdt_tout_flag_o | output | 1 | Sticky time-out flag |

## Verification
Most wrong internal states appear at the ports as a request that comes too early or too late. The error in the count equals the error in the interval. A prescaler that misses a clear or an idle hold shifts the request by up to one prescaler period. A wrong tap-chain stage doubles or halves the interval. Because of this, the bench measures the cycle distance to each request against 2^(BASE_EXP+n), with no tolerance. It also reads back the register after each write, so an error in a stored field appears on the very next read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned WDT_DATA_W    = 8;
   localparam int unsigned WDT_F_EN      = 7;
   localparam int unsigned WDT_F_CLR     = 6;
   localparam int unsigned WDT_F_IDLE    = 5;
   localparam int unsigned WDT_F_SEL_LSB = 0;
   localparam int unsigned WDT_SEL_MAX_W = 3;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 32'h8F,
   parameter int unsigned SEL_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     sfr_addr,
   input  logic                  sfr_wr,
   input  logic [WDT_DATA_W-1:0] sfr_wdata,
   output logic [WDT_DATA_W-1:0] sfr_rdata,
   output logic                  en_o,
   output logic                  idle_run_o,
   output logic [SEL_W-1:0]      sel_o,
   output logic                  restart_o
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   logic             hit;
   logic             wr_hit;
   logic             en_q;
   logic             idle_q;
   logic [SEL_W-1:0] sel_q;
   logic             unused_wbits;

   assign hit          = (sfr_addr == HIT_ADDR);
   assign wr_hit       = sfr_wr & hit;
   assign restart_o    = wr_hit & sfr_wdata[WDT_F_CLR];
   assign unused_wbits = ^sfr_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         idle_q <= 1'b0;
         sel_q  <= '0;
      end else if (wr_hit) begin
         en_q   <= sfr_wdata[WDT_F_EN];
         idle_q <= sfr_wdata[WDT_F_IDLE];
         sel_q  <= sfr_wdata[WDT_F_SEL_LSB +: SEL_W];
      end
   end

   always_comb begin
      sfr_rdata = '0;
      if (hit) begin
         sfr_rdata[WDT_F_EN]               = en_q;
         sfr_rdata[WDT_F_IDLE]             = idle_q;
         sfr_rdata[WDT_F_SEL_LSB +: SEL_W] = sel_q;
      end
   end

   assign en_o       = en_q;
   assign idle_run_o = idle_q;
   assign sel_o      = sel_q;

   AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rdata[6] == 1'b0) && (sfr_rdata[4:3] == 2'b00)); // R2

   AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && !hit) |=> $stable({en_o, idle_run_o, sel_o})); // R10
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRE_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   output logic             tick_o,
   output logic [PRE_W-1:0] value_o
);
   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + PRE_W'(1);
   end

   assign tick_o  = run_i & (&cnt_q);
   assign value_o = cnt_q;

   AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (value_o == '0)); // R6

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R3
endmodule

// File: rtl/wdt_tap_chain.sv
module wdt_tap_chain #(
   parameter int unsigned SEL_W = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      tick_i,
   input  logic [SEL_W-1:0]          sel_i,
   output logic                      tout_o,
   output logic [(1<<SEL_W)-2:0]     upper_o
);
   localparam int unsigned NUM_TAPS = 1 << SEL_W;
   localparam int unsigned UP_W     = NUM_TAPS - 1;

   logic [UP_W-1:0]     up_q;
   logic [NUM_TAPS-1:0] reach;

   assign reach[0] = 1'b1;
   for (genvar n = 1; n < NUM_TAPS; n++) begin : g_reach
      assign reach[n] = reach[n-1] & up_q[n-1];
   end

   assign tout_o = tick_i & reach[sel_i];

   always_ff @(posedge clk) begin
      if (!rst_n)       up_q <= '0;
      else if (clr_i)   up_q <= '0;
      else if (tout_o)  up_q <= '0;
      else if (tick_i)  up_q <= up_q + UP_W'(1);
   end

   assign upper_o = up_q;

   AST_UPPER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      tout_o |=> (upper_o == '0)); // R3
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 32'h8F,
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned SEL_W    = 3,
   parameter bit          REQ_REG  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     sfr_addr,
   input  logic                  sfr_wr,
   input  logic [WDT_DATA_W-1:0] sfr_wdata,
   output logic [WDT_DATA_W-1:0] sfr_rdata,
   input  logic                  idle_i,
   output logic                  wdt_rst_req_o,
   output logic                  wdt_tout_flag_o
);
   localparam int unsigned UP_W = (1 << SEL_W) - 1;

   initial begin
      assert (BASE_EXP >= 1) else $fatal(1, "BASE_EXP must be at least 1");
      assert (SEL_W >= 1 && SEL_W <= WDT_SEL_MAX_W) else $fatal(1, "SEL_W out of range");
      assert (ADDR_W >= 1 && ADDR_W <= 32) else $fatal(1, "ADDR_W out of range");
   end

   logic             en;
   logic             idle_run;
   logic [SEL_W-1:0] sel;
   logic             restart;
   logic             cnt_en;
   logic             clr_all;
   logic             tick;
   logic             tout;
   logic [BASE_EXP-1:0] pre_val;
   logic [UP_W-1:0]  up_val;
   logic             flag_q;

   wdt_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SEL_W(SEL_W)) u_reg (
      .clk, .rst_n, .sfr_addr, .sfr_wr, .sfr_wdata, .sfr_rdata,
      .en_o(en), .idle_run_o(idle_run), .sel_o(sel), .restart_o(restart)
   );

   assign cnt_en  = en & (~idle_i | idle_run);
   assign clr_all = restart | ~en;

   wdt_prescaler #(.PRE_W(BASE_EXP)) u_pre (
      .clk, .rst_n, .clr_i(clr_all), .run_i(cnt_en), .tick_o(tick), .value_o(pre_val)
   );

   wdt_tap_chain #(.SEL_W(SEL_W)) u_taps (
      .clk, .rst_n, .clr_i(clr_all), .tick_i(tick), .sel_i(sel),
      .tout_o(tout), .upper_o(up_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (tout) flag_q <= 1'b1;
   end
   assign wdt_tout_flag_o = flag_q;

   if (REQ_REG) begin : g_req_reg
      logic req_q;
      always_ff @(posedge clk) begin
         if (!rst_n) req_q <= 1'b0;
         else        req_q <= tout;
      end
      assign wdt_rst_req_o = req_q;

      AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         wdt_rst_req_o |-> wdt_tout_flag_o); // R5
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !wdt_rst_req_o); // R9
   end else begin : g_req_comb
      assign wdt_rst_req_o = tout;

      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !en |-> !wdt_rst_req_o); // R9
   end

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req_o |=> !wdt_rst_req_o); // R4

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_tout_flag_o |=> wdt_tout_flag_o); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && idle_i && !idle_run && !restart) |=> $stable({up_val, pre_val})); // R7

   AST_IDLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && idle_i && idle_run && !restart) |=> (pre_val == $past(pre_val) + BASE_EXP'(1))); // R8

   AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pre_val == '0 && up_val == '0)); // R9
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
   localparam int unsigned BE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h8F;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       idle_i = 1'b0;
   logic       wdt_rst_req_o;
   logic       wdt_tout_flag_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   wdog_timer #(.BASE_EXP(BE)) u_dut (
      .clk, .rst_n, .sfr_addr, .sfr_wr, .sfr_wdata, .sfr_rdata,
      .idle_i, .wdt_rst_req_o, .wdt_tout_flag_o
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; idle_i = 1'b0; sfr_wr = 1'b0; sfr_addr = 8'h8F;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0; sfr_addr = 8'h8F;
   endtask

   task automatic wait_pulse(input int limit, output int got);
      got = -1;
      for (int k = 1; k <= limit; k++) begin
         @(negedge clk);
         if (wdt_rst_req_o) begin
            got = k;
            return;
         end
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rdata", int'(sfr_rdata), 0);
      chk("R1 req", int'(wdt_rst_req_o), 0);
      chk("R1 flag", int'(wdt_tout_flag_o), 0);
   endtask

   task automatic t_readback();
      do_reset();
      wr_reg(8'h8F, 8'hFF);
      chk("R2 readback FF", int'(sfr_rdata), 'hA7);
      wr_reg(8'h8F, 8'h00);
      chk("R2 readback 00", int'(sfr_rdata), 0);
      wr_reg(8'h8F, 8'h25);
      chk("R2 readback 25", int'(sfr_rdata), 'h25);
      @(negedge clk); sfr_addr = 8'h8E;
      @(negedge clk);
      chk("R2 other addr reads 0", int'(sfr_rdata), 0);
      sfr_addr = 8'h8F;
   endtask

   task automatic t_foreign();
      int got;
      do_reset();
      wr_reg(8'h8E, 8'h80);
      chk("R10 reg unchanged", int'(sfr_rdata), 0);
      wait_pulse(40, got);
      chk("R10 no time-out", got, -1);
   endtask

   task automatic t_interval(input int code);
      int n, got, got2;
      n = 1 << (BE + code);
      do_reset();
      wr_reg(8'h8F, 8'h80 | 8'(code));
      chk("R3 no req at enable", int'(wdt_rst_req_o), 0);
      wait_pulse(n + 8, got);
      chk($sformatf("R3 first interval code %0d", code), got, n);
      @(negedge clk);
      chk("R4 pulse one cycle", int'(wdt_rst_req_o), 0);
      chk("R5 flag set", int'(wdt_tout_flag_o), 1);
      wait_pulse(n + 8, got2);
      chk($sformatf("R3 period code %0d", code), got2 + 1, n);
   endtask

   task automatic t_flag();
      int got;
      t_interval(0);
      wr_reg(8'h8F, 8'h00);
      repeat (30) @(negedge clk);
      chk("R5 flag sticky", int'(wdt_tout_flag_o), 1);
      wait_pulse(5, got);
      chk("R9 no req disabled", got, -1);
      do_reset();
      chk("R5 flag cleared by reset", int'(wdt_tout_flag_o), 0);
   endtask

   task automatic t_restart();
      int got;
      do_reset();
      wr_reg(8'h8F, 8'h82);
      wait_pulse(20, got);
      chk("R6 no early req", got, -1);
      wr_reg(8'h8F, 8'hC2);
      chk("R6 restart bit reads 0", int'(sfr_rdata), 'h82);
      wait_pulse(80, got);
      chk("R6 full interval after restart", got, 32);
   endtask

   task automatic t_idle_hold();
      int got;
      got = -1;
      do_reset();
      wr_reg(8'h8F, 8'h81);
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (wdt_rst_req_o && got < 0) got = k;
         if (k == 5)  idle_i = 1'b1;
         if (k == 15) idle_i = 1'b0;
      end
      chk("R7 idle stretches interval", got, 26);
   endtask

   task automatic t_idle_run();
      int got;
      do_reset();
      idle_i = 1'b1;
      wr_reg(8'h8F, 8'hA1);
      chk("R2 readback A1", int'(sfr_rdata), 'hA1);
      wait_pulse(40, got);
      chk("R8 idle-run interval", got, 16);
      idle_i = 1'b0;
   endtask

   task automatic t_disabled();
      int got;
      do_reset();
      wr_reg(8'h8F, 8'h03);
      wait_pulse(200, got);
      chk("R9 disabled no req", got, -1);
      chk("R9 disabled flag low", int'(wdt_tout_flag_o), 0);
      wr_reg(8'h8F, 8'h80);
      wait_pulse(20, got);
      chk("R9 full interval after enable", got, 8);
   endtask

   initial begin
      t_reset();
      t_readback();
      t_foreign();
      t_interval(0);
      t_interval(2);
      t_interval(7);
      t_flag();
      t_restart();
      t_idle_hold();
      t_idle_run();
      t_disabled();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule